// File: doc/BRIEF.md
# Panel Controller Shadowed Register Bank

This block holds the configuration of a display panel controller behind a simple 32-bit bus with a single write strobe and a combinational read port. Software writes to a configuration register land only in a shadow copy. The copy that the downstream timing and fetch logic sees is the active one. It stays unchanged until software writes 1 to a global commit register. On that write every shadow copy moves into its active copy on the same clock edge, so a partly written set of settings never reaches the panel.

The same bank keeps the interrupt state. Four event pulses come in from the display engine: frame end, display end, per-frame and line flag. Each pulse sets a sticky status bit. One register holds the four status bits, four mask bits and four write-one-to-clear bits in separate groups. The interrupt line is high while any status bit is set whose mask bit is 0.

Top module: `panel_ctl_regbank`

## Requirements
- R1: After reset every shadow copy, every active copy, all status bits and all mask bits are 0, and `irq_out` is 0.
- R2: A write to a configuration register reads back at once through the shadow copy, but its active copy on `active_cfg` keeps its old value until a commit.
- R3: A write to offset 0x50 with data bit 0 set copies all twelve shadow registers into their active copies on that clock edge. The same write with bit 0 clear has no effect.
- R4: `evt_in` bit 0 is frame end, bit 1 display end, bit 2 per-frame and bit 3 line flag. A pulse sets status bit n (bits 3..0 of offset 0x3C), and the bit stays set until it is cleared.
- R5: Bits 7..4 of offset 0x3C are read/write mask bits for events 0..3 in that order. A set mask bit keeps its event out of `irq_out`, but the status bit is still recorded.
- R6: Writing 1 to bit 8+n of offset 0x3C clears status bit n, and writing 0 there leaves it alone. Bits 11..8 read as 0.
- R7: If an event pulse and a clear of the same bit fall in the same cycle, the status bit ends up set.
- R8: `irq_out` is 1 exactly when some status bit n is 1 and mask bit n is 0.
- R9: Reads of an unmapped offset, and of the commit offset 0x50, return 0. Writes to unmapped offsets change no register.
- R10: Writes to bits 3..0 of offset 0x3C never set a status bit.
- R11: The configuration registers sit at offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x24 (previous image base), 0x28 (current image base), 0x54 (line-flag line number) and 0x58 (frame-count buffer base). They map in that order to `active_cfg` slots 0 to 11, and slot k occupies bits 32k+31..32k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| evt_in | input | 4 | Event pulses: frame end, display end, per-frame, line flag |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| active_cfg | output | 384 | Active copies of the twelve configuration registers |
| irq_out | output | 1 | Masked OR of the status bits |

## Verification
The bench attacks how shadow and active copies are separated. It writes registers and then checks `active_cfg` before and after a commit, and it sends a commit with bit 0 clear. A design that let writes through at once, or that committed on any write to 0x50, would show new values too early. It also drives an event and its clear in the same cycle, writes ones into the status field, and masks some events while leaving others unmasked. A design where the clear wins, where the status field can be written, or where the mask polarity is inverted gives the wrong status readback or a wrong `irq_out`. Unmapped and commit-offset reads are checked for 0 after writes to those offsets.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

   localparam int NUM_SLOTS  = 12;
   localparam int OFF_BITS   = 12;

   localparam logic [OFF_BITS-1:0] STATUS_OFF = 12'h03C;
   localparam logic [OFF_BITS-1:0] COMMIT_OFF = 12'h050;

   // Byte offset of each shadowed configuration slot; slot order is the
   // order of the active output bundle.
   function automatic logic [OFF_BITS-1:0] slot_offset(input int idx);
      logic [OFF_BITS-1:0] off;
      case (idx)
         0:       off = 12'h000;
         1:       off = 12'h004;
         2:       off = 12'h008;
         3:       off = 12'h00C;
         4:       off = 12'h010;
         5:       off = 12'h014;
         6:       off = 12'h018;
         7:       off = 12'h01C;
         8:       off = 12'h024;
         9:       off = 12'h028;
         10:      off = 12'h054;
         11:      off = 12'h058;
         default: off = 12'hFFC;
      endcase
      return off;
   endfunction

endpackage

// File: rtl/pcr_addr_decode.sv
module pcr_addr_decode #(
   parameter int ADDR_W    = 12,
   parameter int NUM_SLOTS = pcr_pkg::NUM_SLOTS
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [NUM_SLOTS-1:0] slot_sel,
   output logic                 status_sel,
   output logic                 commit_sel
);

   localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(pcr_pkg::STATUS_OFF);
   localparam logic [ADDR_W-1:0] CMT_A = ADDR_W'(pcr_pkg::COMMIT_OFF);

   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("pcr_addr_decode: ADDR_W must cover offset 0x58");
      end
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(pcr_pkg::slot_offset(g));
         assign slot_sel[g] = (addr == SLOT_A);
      end
   endgenerate

   assign status_sel = (addr == STS_A);
   assign commit_sel = (addr == CMT_A);

endmodule

// File: rtl/pcr_shadow_slot.sv
module pcr_shadow_slot #(
   parameter int               DATA_W  = 32,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              commit,
   output logic [DATA_W-1:0] shadow_q,
   output logic [DATA_W-1:0] active_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= RST_VAL;
      end else if (wr_en) begin
         shadow_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= RST_VAL;
      end else if (commit) begin
         active_q <= shadow_q;
      end
   end

   // R2: without a commit the active copy never moves
   a_r2_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(active_q));

   // R3: a commit publishes the shadow value held on that edge
   a_r3_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (active_q == $past(shadow_q)));

endmodule

// File: rtl/pcr_irq_status.sv
module pcr_irq_status #(
   parameter int DATA_W  = 32,
   parameter int NUM_EVT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NUM_EVT-1:0] evt,
   output logic [NUM_EVT-1:0] sts_q,
   output logic [NUM_EVT-1:0] msk_q,
   output logic              irq_o
);

   localparam int MSK_LO = NUM_EVT;
   localparam int CLR_LO = 2 * NUM_EVT;

   logic [NUM_EVT-1:0] clr_req;

   assign clr_req = wr_en ? wdata[CLR_LO +: NUM_EVT] : '0;

   generate
      if (3 * NUM_EVT > DATA_W) begin : g_bad_width
         $error("pcr_irq_status: three event fields do not fit DATA_W");
      end
      for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sts_q[e] <= 1'b0;
            end else if (evt[e]) begin
               sts_q[e] <= 1'b1;
            end else if (clr_req[e]) begin
               sts_q[e] <= 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msk_q <= '0;
      end else if (wr_en) begin
         msk_q <= wdata[MSK_LO +: NUM_EVT];
      end
   end

   assign irq_o = |(sts_q & ~msk_q);

   // R7: an event pulse always leaves its status bit set
   a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((sts_q & $past(evt)) == $past(evt)));

   // R6: a clear without a competing event drops the bit
   a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((sts_q & $past(clr_req & ~evt)) == '0));

   // R4: a status bit only falls through an explicit clear
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~sts_q & $past(sts_q) & ~$past(clr_req)) == '0));

   // R10: no status bit rises without an event
   a_r10_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(evt)) == '0));

endmodule

// File: rtl/panel_ctl_regbank.sv
module panel_ctl_regbank #(
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32,
   parameter int NUM_EVT = 4,
   parameter int NUM_SLOTS = pcr_pkg::NUM_SLOTS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   input  logic [NUM_EVT-1:0]          evt_in,
   output logic [DATA_W-1:0]           bus_rdata,
   output logic [NUM_SLOTS*DATA_W-1:0] active_cfg,
   output logic                        irq_out
);

   logic [NUM_SLOTS-1:0] slot_sel;
   logic                 status_sel;
   logic                 commit_sel;
   logic                 commit;
   logic [DATA_W-1:0]    shadow_w [NUM_SLOTS];
   logic [NUM_EVT-1:0]   sts_w;
   logic [NUM_EVT-1:0]   msk_w;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("panel_ctl_regbank: DATA_W must be positive");
      end
   endgenerate

   pcr_addr_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_SLOTS (NUM_SLOTS)
   ) u_dec (
      .addr       (bus_addr),
      .slot_sel   (slot_sel),
      .status_sel (status_sel),
      .commit_sel (commit_sel)
   );

   assign commit = bus_wr & commit_sel & bus_wdata[0];

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cfg
         pcr_shadow_slot #(
            .DATA_W  (DATA_W),
            .RST_VAL ('0)
         ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr & slot_sel[s]),
            .wdata    (bus_wdata),
            .commit   (commit),
            .shadow_q (shadow_w[s]),
            .active_q (active_cfg[s*DATA_W +: DATA_W])
         );
      end
   endgenerate

   pcr_irq_status #(
      .DATA_W  (DATA_W),
      .NUM_EVT (NUM_EVT)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (bus_wr & status_sel),
      .wdata (bus_wdata),
      .evt   (evt_in),
      .sts_q (sts_w),
      .msk_q (msk_w),
      .irq_o (irq_out)
   );

   always_comb begin
      bus_rdata = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (slot_sel[s]) begin
            bus_rdata = bus_rdata | shadow_w[s];
         end
      end
      if (status_sel) begin
         bus_rdata[NUM_EVT-1:0]         = sts_w;
         bus_rdata[NUM_EVT +: NUM_EVT]  = msk_w;
      end
   end

   // R9: the commit offset reads as zero
   a_r9_commit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      commit_sel |-> (bus_rdata == '0));

   // R8: the interrupt line implies a pending unmasked status bit
   a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ((sts_w & ~msk_w) != '0));

endmodule

// File: tb/panel_ctl_regbank_bench.sv
module panel_ctl_regbank_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NS = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [3:0]    evt_in = '0;
   logic [31:0]   bus_rdata;
   logic [NS*32-1:0] active_cfg;
   logic          irq_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [31:0] m_sh [NS];
   logic [31:0] m_ac [NS];
   logic [3:0]  m_sts;
   logic [3:0]  m_msk;

   always #(CLK_PERIOD/2) clk = ~clk;

   panel_ctl_regbank u_panel_ctl_regbank (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .evt_in     (evt_in),
      .bus_rdata  (bus_rdata),
      .active_cfg (active_cfg),
      .irq_out    (irq_out)
   );

   function automatic logic [11:0] off_of(input int k);
      logic [11:0] t [NS] = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014,
                              12'h018, 12'h01C, 12'h024, 12'h028, 12'h054, 12'h058};
      return t[k];
   endfunction

   function automatic int slot_of(input logic [11:0] a);
      for (int k = 0; k < NS; k++) if (off_of(k) == a) return k;
      return -1;
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      int k = slot_of(a);
      if (k >= 0) return m_sh[k];
      if (a == 12'h03C) return {24'd0, m_msk, m_sts};
      return 32'd0;
   endfunction

   function automatic logic exp_irq();
      return |(m_sts & ~m_msk);
   endfunction

   function automatic logic [NS*32-1:0] exp_active();
      logic [NS*32-1:0] v;
      for (int k = 0; k < NS; k++) v[k*32 +: 32] = m_ac[k];
      return v;
   endfunction

   task automatic chk(input string req, input logic [NS*32-1:0] act,
                      input logic [NS*32-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One clock: drive the access and events, update the model on the edge
   task automatic tick(input logic wr, input logic [11:0] a,
                       input logic [31:0] d, input logic [3:0] ev);
      int k;
      logic [3:0] clr;
      bus_wr = wr; bus_addr = a; bus_wdata = d; evt_in = ev;
      @(posedge clk);
      k = slot_of(a);
      clr = 4'd0;
      if (wr) begin
         if (a == 12'h050 && d[0]) for (int j = 0; j < NS; j++) m_ac[j] = m_sh[j];
         if (k >= 0) m_sh[k] = d;
         if (a == 12'h03C) begin
            m_msk = d[7:4];
            clr = d[11:8];
         end
      end
      m_sts = (m_sts & ~clr) | ev;
      #1;
      bus_wr = 1'b0; evt_in = 4'd0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a);
      bus_addr = a;
      #1;
      chk(req, {{(NS-1)*32{1'b0}}, bus_rdata}, {{(NS-1)*32{1'b0}}, exp_read(a)});
   endtask

   task automatic out_chk(input string req);
      chk(req, active_cfg, exp_active());
      chk(req, {{(NS*32-1){1'b0}}, irq_out}, {{(NS*32-1){1'b0}}, exp_irq()});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      for (int k = 0; k < NS; k++) begin m_sh[k] = '0; m_ac[k] = '0; end
      m_sts = '0; m_msk = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #2;

      // R1: reset state
      out_chk("R1");
      for (int k = 0; k < NS; k++) rd_chk("R1", off_of(k));
      rd_chk("R1", 12'h03C);

      // R2 / R11: distinct values to every slot, shadow visible, active held
      for (int k = 0; k < NS; k++) tick(1'b1, off_of(k), 32'hA5000000 + 32'(k * 32'h10101), 4'd0);
      for (int k = 0; k < NS; k++) rd_chk("R11", off_of(k));
      out_chk("R2");

      // R3: commit with bit 0 clear does nothing, with bit 0 set publishes
      tick(1'b1, 12'h050, 32'hFFFF_FFFE, 4'd0);
      out_chk("R3");
      tick(1'b1, 12'h050, 32'h0000_0001, 4'd0);
      out_chk("R3");

      // R2: later write stays in the shadow until the next commit
      tick(1'b1, 12'h054, 32'h0000_01E0, 4'd0);
      rd_chk("R2", 12'h054);
      out_chk("R2");
      tick(1'b1, 12'h050, 32'h1, 4'd0);
      out_chk("R3");

      // R9: unmapped and commit offsets
      tick(1'b1, 12'h040, 32'hDEAD_BEEF, 4'd0);
      tick(1'b1, 12'h020, 32'h1234_5678, 4'd0);
      rd_chk("R9", 12'h040);
      rd_chk("R9", 12'h020);
      rd_chk("R9", 12'h050);
      rd_chk("R9", 12'h026);
      out_chk("R9");

      // R4: each event sets its own sticky bit
      for (int e = 0; e < 4; e++) begin
         tick(1'b0, 12'h000, 32'd0, 4'(1 << e));
         rd_chk("R4", 12'h03C);
      end
      tick(1'b0, 12'h000, 32'd0, 4'd0);
      rd_chk("R4", 12'h03C);
      out_chk("R8");

      // R5 / R8: mask everything, then unmask one
      tick(1'b1, 12'h03C, 32'h0000_00F0, 4'd0);
      out_chk("R5");
      tick(1'b1, 12'h03C, 32'h0000_00B0, 4'd0);
      out_chk("R8");

      // R6: clear bit 2 only, clear field reads 0
      tick(1'b1, 12'h03C, 32'h0000_04B0, 4'd0);
      rd_chk("R6", 12'h03C);
      out_chk("R6");

      // R7: event and clear on bit 1 in the same cycle
      tick(1'b1, 12'h03C, 32'h0000_0200, 4'b0010);
      rd_chk("R7", 12'h03C);
      out_chk("R7");

      // R10: clear all, then try to set status by writing ones
      tick(1'b1, 12'h03C, 32'h0000_0F00, 4'd0);
      tick(1'b1, 12'h03C, 32'h0000_000F, 4'd0);
      rd_chk("R10", 12'h03C);
      out_chk("R10");

      // Random mix
      for (int it = 0; it < 400; it++) begin
         int op = int'($urandom % 6);
         logic [31:0] d = $urandom;
         logic [3:0] ev = ($urandom % 4 == 0) ? 4'($urandom) : 4'd0;
         case (op)
            0, 1: tick(1'b1, off_of(int'($urandom % NS)), d, ev);
            2:    tick(1'b1, 12'h050, d, ev);
            3:    tick(1'b1, 12'h03C, d, ev);
            4:    tick(1'b1, 12'(($urandom % 64) * 4), d, ev);
            default: tick(1'b0, 12'h000, d, ev);
         endcase
         out_chk("R3");
         rd_chk("R2", off_of(int'($urandom % NS)));
         rd_chk("R4", 12'h03C);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule